// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block carries out one erase of a single 64 KiB block in a byte-wide, command-driven flash device, and then proves the block blank by reading it back. A parent controller pulses `start` with a block number. The sequencer then runs the whole command exchange on a simple memory bus. The exchange has dummy reads, a status clear, the erase and confirm bytes aimed at the middle of the block, timed status polling, and a return to read mode. A blank scan of every 32-bit word in the block follows. Each group of command writes is preceded by a one-cycle write-gate pulse, which opens the external write path.

Time is measured in ticks of an external millisecond strobe. The status byte is polled every 10 ticks, up to a limit of 10 000 ticks. When the sequence ends, a one-cycle `done` pulse comes with a 2-bit result code. For a blank-check failure, the index of the first bad word is also reported. The block makes one attempt only: any retry belongs to the parent.

The bus is single-cycle. Read data on `bus_rdata` belongs to the address presented in the same cycle. Status reads use the low byte.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `wgate`, `bus_rd` and `bus_wr` are all low.
- R2: After `start`, the first bus operations are a dummy read at address 0x8000 and then a write of 0x50 to address 0x8000.
- R3: The target address is block×65536+0x8000. It receives a dummy read, then a write of 0x20, then a write of 0xD0, with no other write in between.
- R4: `wgate` pulses for one cycle immediately before each group of command writes. Every bus write is directly preceded by either a `wgate` cycle or another write.
- R5: Status reads go to the target address, and ready is `bus_rdata[7]`. The k-th status read comes exactly 10·k ticks after the confirm write.
- R6: If the status read at 10 000 ticks does not show ready, the result is 2 (timeout). If ready appears on that same read, the run proceeds as a normal success.
- R7: When polling ends for any reason, 0xFF is written to the target address.
- R8: If the final status shows ready with bit 5 (`bus_rdata[5]`) set, the block writes 0x50 to address 0x8000, does no scan, and returns result 1.
- R9: On a clean status, the scan starts exactly 10 ticks after the 0xFF write. It reads word i at block×65536+4·i, in increasing i, one word per cycle, for i from 0 to 16383.
- R10: The scan stops at the first word that is not 0xFFFFFFFF. The result is then 3, and `fail_word` holds that word's index.
- R11: When all 16384 words read 0xFFFFFFFF, the result is 0.
- R12: `done` is a one-cycle pulse that comes in the cycle `busy` falls. `result` holds its value until the next accepted start.
- R13: A `start` pulse while `busy` is high is ignored, and the running erase keeps its own block number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an erase when idle |
| blk_num | input | 6 | Block to erase |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 erase error, 2 timeout, 3 blank fail |
| fail_word | output | 14 | Index of first non-blank word |
| wgate | output | 1 | Write-gate open pulse |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus byte write strobe |
| bus_addr | output | 22 | Bus byte address |
| bus_wdata | output | 8 | Command byte |
| bus_rdata | input | 32 | Read data for the address of the same cycle |

## Verification
The timeout limit and the ready bit can fall on the same status read. In that case the ready bit must win. The bench provokes this by having its flash model report ready only on the 1000th poll, which falls exactly at 10 000 ticks. It judges the outcome by expecting result 0 and a full 16384-word scan, not a timeout code. The other polling runs vary the tick spacing at random, and every poll's tick distance from the confirm write is checked against its multiple of 10.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [1:0] {
        RES_OK         = 2'd0,
        RES_ERASE_ERR  = 2'd1,
        RES_TIMEOUT    = 2'd2,
        RES_BLANK_FAIL = 2'd3
    } fes_result_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_CMN, ST_GATE_CLR, ST_WR_CLR,
        ST_RD_TGT, ST_GATE_ERA, ST_WR_ERA, ST_WR_CONF,
        ST_WAIT, ST_POLL, ST_GATE_RDM, ST_WR_RDM,
        ST_GATE_ACK, ST_WR_ACK, ST_SETTLE, ST_SCAN
    } fes_state_e;

    typedef enum logic [1:0] {
        ADR_COMMON, ADR_TARGET, ADR_SCAN
    } fes_addr_sel_e;

    typedef struct packed {
        logic          rd;
        logic          wr;
        logic [7:0]    wdata;
        fes_addr_sel_e sel;
    } fes_bus_op_t;

    localparam logic [7:0] CMD_CLR_STAT = 8'h50;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_CONFIRM  = 8'h D0;
    localparam logic [7:0] CMD_READ     = 8'hFF;
    localparam int STAT_READY_BIT = 7;
    localparam int STAT_ERR_BIT   = 5;

    function automatic fes_bus_op_t fes_bus_op(fes_state_e s);
        fes_bus_op_t op;
        op = '{rd: 1'b0, wr: 1'b0, wdata: 8'h00, sel: ADR_COMMON};
        case (s)
            ST_RD_CMN:  op.rd = 1'b1;
            ST_WR_CLR:  begin op.wr = 1'b1; op.wdata = CMD_CLR_STAT; end
            ST_RD_TGT:  begin op.rd = 1'b1; op.sel = ADR_TARGET; end
            ST_WR_ERA:  begin op.wr = 1'b1; op.wdata = CMD_ERASE;   op.sel = ADR_TARGET; end
            ST_WR_CONF: begin op.wr = 1'b1; op.wdata = CMD_CONFIRM; op.sel = ADR_TARGET; end
            ST_POLL:    begin op.rd = 1'b1; op.sel = ADR_TARGET; end
            ST_WR_RDM:  begin op.wr = 1'b1; op.wdata = CMD_READ;    op.sel = ADR_TARGET; end
            ST_WR_ACK:  begin op.wr = 1'b1; op.wdata = CMD_CLR_STAT; end
            ST_SCAN:    begin op.rd = 1'b1; op.sel = ADR_SCAN; end
            default:    ;
        endcase
        return op;
    endfunction

    function automatic logic fes_is_gate(fes_state_e s);
        return (s == ST_GATE_CLR) || (s == ST_GATE_ERA) ||
               (s == ST_GATE_RDM) || (s == ST_GATE_ACK);
    endfunction

endpackage

// File: rtl/fes_tick_timer.sv
module fes_tick_timer #(
    parameter int INT_W = 4,
    parameter int EL_W  = 14,
    parameter int LIMIT = 10000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             int_en,
    input  logic [INT_W-1:0] int_target,
    input  logic             el_clr,
    input  logic             el_en,
    output logic             int_hit,
    output logic             lim_hit
);
    logic [INT_W-1:0] int_cnt;
    logic [EL_W-1:0]  el_cnt;

    assign int_hit = int_en && tick && (int_cnt == int_target - INT_W'(1));
    assign lim_hit = (el_cnt >= EL_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || !int_en) begin
            int_cnt <= '0;
        end else if (tick) begin
            int_cnt <= int_hit ? '0 : int_cnt + INT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || el_clr) begin
            el_cnt <= '0;
        end else if (el_en && tick && !lim_hit) begin
            el_cnt <= el_cnt + EL_W'(1);
        end
    end
endmodule

// File: rtl/fes_blank_scan.sv
module fes_blank_scan #(
    parameter int IDX_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [31:0]      rdata,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic             blank
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + IDX_W'(1);
        end
    end

    assign last  = (idx == {IDX_W{1'b1}});
    assign blank = (rdata == 32'hFFFF_FFFF);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int BLK_LOG2  = 16,
    parameter int POLL_MS   = 10,
    parameter int SETTLE_MS = 10,
    parameter int LIMIT_MS  = 10000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [ADDR_W-BLK_LOG2-1:0] blk_num,
    input  logic                       ms_tick,
    output logic                       busy,
    output logic                       done,
    output logic [1:0]                 result,
    output logic [BLK_LOG2-3:0]        fail_word,
    output logic                       wgate,
    output logic                       bus_rd,
    output logic                       bus_wr,
    output logic [ADDR_W-1:0]          bus_addr,
    output logic [7:0]                 bus_wdata,
    input  logic [31:0]                bus_rdata
);
    localparam int BLK_W  = ADDR_W - BLK_LOG2;
    localparam int IDX_W  = BLK_LOG2 - 2;
    localparam int TMAX   = (POLL_MS > SETTLE_MS) ? POLL_MS : SETTLE_MS;
    localparam int TCNT_W = $clog2(TMAX + 1);
    localparam int EL_W   = $clog2(LIMIT_MS + 1);
    localparam logic [BLK_LOG2-1:0] MID_OFS = {1'b1, {(BLK_LOG2-1){1'b0}}};

    fes_state_e   state_q, state_d;
    logic [BLK_W-1:0] blk_q;
    logic [7:0]   stat_q;
    logic         tmo_q;
    logic         done_q;
    fes_result_e  res_q;
    logic [IDX_W-1:0] fail_q;
    logic         fin;
    fes_result_e  fin_code;
    fes_bus_op_t  op;

    logic             int_hit, lim_hit, int_en, el_en, el_clr;
    logic [TCNT_W-1:0] int_target;
    logic [IDX_W-1:0] scan_idx;
    logic             scan_last, scan_blank, scan_step;

    assign int_en     = (state_q == ST_WAIT) || (state_q == ST_POLL) || (state_q == ST_SETTLE);
    assign int_target = (state_q == ST_SETTLE) ? TCNT_W'(SETTLE_MS) : TCNT_W'(POLL_MS);
    assign el_clr     = (state_q == ST_WR_CONF);
    assign el_en      = (state_q == ST_WAIT) || (state_q == ST_POLL);

    fes_tick_timer #(.INT_W(TCNT_W), .EL_W(EL_W), .LIMIT(LIMIT_MS)) u_timer (
        .clk(clk), .rst(rst), .tick(ms_tick),
        .int_en(int_en), .int_target(int_target),
        .el_clr(el_clr), .el_en(el_en),
        .int_hit(int_hit), .lim_hit(lim_hit)
    );

    assign scan_step = (state_q == ST_SCAN) && scan_blank && !scan_last;

    fes_blank_scan #(.IDX_W(IDX_W)) u_scan (
        .clk(clk), .rst(rst), .clr(state_q == ST_IDLE), .step(scan_step),
        .rdata(bus_rdata), .idx(scan_idx), .last(scan_last), .blank(scan_blank)
    );

    // Bus drive decoded from the current state
    always_comb begin
        op        = fes_bus_op(state_q);
        bus_rd    = op.rd;
        bus_wr    = op.wr;
        bus_wdata = op.wdata;
        case (op.sel)
            ADR_TARGET: bus_addr = {blk_q, MID_OFS};
            ADR_SCAN:   bus_addr = {blk_q, scan_idx, 2'b00};
            default:    bus_addr = {{BLK_W{1'b0}}, MID_OFS};
        endcase
    end

    assign wgate     = fes_is_gate(state_q);
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign result    = res_q;
    assign fail_word = fail_q;

    always_comb begin
        state_d  = state_q;
        fin      = 1'b0;
        fin_code = RES_OK;
        case (state_q)
            ST_IDLE:     if (start) state_d = ST_RD_CMN;
            ST_RD_CMN:   state_d = ST_GATE_CLR;
            ST_GATE_CLR: state_d = ST_WR_CLR;
            ST_WR_CLR:   state_d = ST_RD_TGT;
            ST_RD_TGT:   state_d = ST_GATE_ERA;
            ST_GATE_ERA: state_d = ST_WR_ERA;
            ST_WR_ERA:   state_d = ST_WR_CONF;
            ST_WR_CONF:  state_d = ST_WAIT;
            ST_WAIT:     if (int_hit) state_d = ST_POLL;
            ST_POLL: begin
                if (bus_rdata[STAT_READY_BIT] || lim_hit) state_d = ST_GATE_RDM;
                else                                     state_d = ST_WAIT;
            end
            ST_GATE_RDM: state_d = ST_WR_RDM;
            ST_WR_RDM: begin
                if (tmo_q) begin
                    fin = 1'b1; fin_code = RES_TIMEOUT;
                end else if (stat_q[STAT_ERR_BIT]) begin
                    state_d = ST_GATE_ACK;
                end else begin
                    state_d = ST_SETTLE;
                end
            end
            ST_GATE_ACK: state_d = ST_WR_ACK;
            ST_WR_ACK:   begin fin = 1'b1; fin_code = RES_ERASE_ERR; end
            ST_SETTLE:   if (int_hit) state_d = ST_SCAN;
            ST_SCAN: begin
                if (!scan_blank)    begin fin = 1'b1; fin_code = RES_BLANK_FAIL; end
                else if (scan_last) begin fin = 1'b1; fin_code = RES_OK; end
            end
            default:     state_d = ST_IDLE;
        endcase
        if (fin) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            blk_q   <= '0;
            stat_q  <= '0;
            tmo_q   <= 1'b0;
            done_q  <= 1'b0;
            res_q   <= RES_OK;
            fail_q  <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= fin;
            if (state_q == ST_IDLE && start) begin
                blk_q  <= blk_num;
                tmo_q  <= 1'b0;
                stat_q <= '0;
                fail_q <= '0;
            end
            if (state_q == ST_POLL) begin
                if (bus_rdata[STAT_READY_BIT]) stat_q <= bus_rdata[7:0];
                else if (lim_hit)              tmo_q  <= 1'b1;
            end
            if (fin) begin
                res_q <= fin_code;
                if (fin_code == RES_BLANK_FAIL) fail_q <= scan_idx;
            end
        end
    end

    // R4: a write only follows a gate pulse or another write
    p_gate_write_r4: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> ($past(wgate) || $past(bus_wr)));

    // R12: done lasts one cycle and accompanies the fall of busy
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_busy_done_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R10: a non-blank scan word ends the run with the blank-fail code
    p_scan_fail_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && state_q == ST_SCAN && bus_rdata != 32'hFFFF_FFFF)
            |=> (done && result == 2'd3));

    // R6: a not-ready poll at the limit leads to the timeout code
    p_timeout_code_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POLL && !bus_rdata[STAT_READY_BIT] && lim_hit)
            |=> ##2 (done && result == 2'd2));

    // R9: reads and writes never share a cycle
    p_bus_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));
endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  blk_num = '0;
    logic        ms_tick = 1'b0;
    logic        busy, done, wgate, bus_rd, bus_wr;
    logic [1:0]  result;
    logic [13:0] fail_word;
    logic [21:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [31:0] bus_rdata;

    flash_erase_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .blk_num(blk_num), .ms_tick(ms_tick),
        .busy(busy), .done(done), .result(result), .fail_word(fail_word),
        .wgate(wgate), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // flash model configuration
    logic [5:0] cfg_blk = '0;
    int  cfg_ready = 1;
    bit  cfg_err = 0;
    bit  cfg_bad_en = 0;
    int  cfg_bad_idx = 0;
    int  tick_gap = 1;
    logic [31:0] cfg_bad_val = 32'h0;
    logic [21:0] tgt_addr, base_addr;
    assign tgt_addr  = {cfg_blk, 16'h8000};
    assign base_addr = {cfg_blk, 16'h0000};

    // monitor state
    bit  mon_clr = 0;
    int  nwr, nrd, ngate, gate_err, polls, poll_err, tick_since;
    int  settle_ticks, settle_err, nscan, scan_err;
    bit  status_mode, scan_phase, gate_prev;
    logic [21:0] wa [0:7];
    logic [7:0]  wd [0:7];
    logic [21:0] ra [0:3];

    logic [7:0] st_byte;
    always_comb begin
        st_byte = 8'h00;
        if (cfg_ready != 0 && polls >= cfg_ready)
            st_byte = cfg_err ? 8'hA0 : 8'h80;
        bus_rdata = 32'hFFFF_FFFF;
        if (status_mode && bus_addr == tgt_addr)
            bus_rdata = {24'h0, st_byte};
        else if (cfg_bad_en && bus_addr == base_addr + 22'(cfg_bad_idx * 4))
            bus_rdata = cfg_bad_val;
    end

    always @(negedge clk) begin
        if (mon_clr) begin
            nwr = 0; nrd = 0; ngate = 0; gate_err = 0; polls = 0; poll_err = 0;
            tick_since = 0; settle_ticks = 0; settle_err = 0; nscan = 0; scan_err = 0;
            status_mode = 0; scan_phase = 0; gate_prev = 0;
        end else begin
            if (bus_rd) begin
                if (status_mode && bus_addr == tgt_addr) begin
                    polls++;
                    if (tick_since != 10 * polls) poll_err++;
                end else if (scan_phase) begin
                    if (nscan == 0 && settle_ticks != 10) settle_err++;
                    if (bus_addr != base_addr + 22'(nscan * 4)) scan_err++;
                    nscan++;
                end else begin
                    if (nrd < 4) ra[nrd] = bus_addr;
                    nrd++;
                end
            end
            if (ms_tick) begin
                tick_since++;
                settle_ticks++;
            end
            if (gate_prev && !bus_wr) gate_err++;
            gate_prev = wgate;
            if (wgate) ngate++;
            if (bus_wr) begin
                if (nwr < 8) begin wa[nwr] = bus_addr; wd[nwr] = bus_wdata; end
                nwr++;
                if (bus_addr == tgt_addr && bus_wdata == 8'hD0) begin
                    status_mode = 1; tick_since = 0;
                end
                if (bus_addr == tgt_addr && bus_wdata == 8'hFF) begin
                    status_mode = 0; scan_phase = 1; settle_ticks = 0;
                end
            end
        end
    end

    // millisecond strobe, one high cycle every tick_gap cycles
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(posedge clk);
            #1;
            cnt++;
            if (cnt >= tick_gap) begin ms_tick = 1'b1; cnt = 0; end
            else ms_tick = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_result(int ready, bit err, bit bad);
        if (ready == 0) return 2;
        if (err)        return 1;
        if (bad)        return 3;
        return 0;
    endfunction

    task automatic run_trial(input logic [5:0] blk, input int ready, input bit err,
                             input bit bad, input int bad_idx, input int gap,
                             input bit mid_start);
        int cycles;
        int er;
        logic [1:0] res_seen;
        @(posedge clk); #1;
        cfg_blk = blk; cfg_ready = ready; cfg_err = err; cfg_bad_en = bad;
        cfg_bad_idx = bad_idx; tick_gap = gap; cfg_bad_val = 32'hFFFF_FFFF ^ (32'h1 << (bad_idx % 32));
        mon_clr = 1;
        @(posedge clk); #1;
        mon_clr = 0; start = 1; blk_num = blk;
        @(posedge clk); #1;
        start = 0;
        if (mid_start) begin
            repeat (30) @(posedge clk);
            #1; start = 1; blk_num = blk ^ 6'h01;
            @(posedge clk); #1; start = 0;
        end
        cycles = 0;
        do begin @(posedge clk); #2; cycles++; end while (!done && cycles < 60000);
        chk(done, "R12 done seen", int'(done), 1);
        chk(!busy, "R12 busy low with done", int'(busy), 0);
        er = exp_result(ready, err, bad);
        chk(int'(result) == er, "R11 R6 R8 R10 result code", int'(result), er);
        res_seen = result;
        // R2 R3 preamble reads and command writes
        chk(nrd == 2 && ra[0] == 22'h8000 && ra[1] == tgt_addr, "R2 R3 dummy reads", nrd, 2);
        chk(nwr == (err && ready != 0 ? 5 : 4), "R8 write count", nwr, (err && ready != 0) ? 5 : 4);
        chk(wa[0] == 22'h8000 && wd[0] == 8'h50, "R2 clear status write", int'(wd[0]), 'h50);
        chk(wa[1] == tgt_addr && wd[1] == 8'h20 && wa[2] == tgt_addr && wd[2] == 8'hD0,
            "R3 erase and confirm at target", int'(wa[1]), int'(tgt_addr));
        chk(wa[3] == tgt_addr && wd[3] == 8'hFF, "R7 read-mode write", int'(wd[3]), 'hFF);
        if (err && ready != 0)
            chk(wa[4] == 22'h8000 && wd[4] == 8'h50, "R8 error clear write", int'(wd[4]), 'h50);
        chk(gate_err == 0 && ngate == ((err && ready != 0) ? 4 : 3), "R4 gate pulses",
            ngate, (err && ready != 0) ? 4 : 3);
        chk(polls == (ready == 0 ? 1000 : ready), "R5 R6 poll count", polls, ready == 0 ? 1000 : ready);
        chk(poll_err == 0, "R5 poll spacing", poll_err, 0);
        if (er == 0 || er == 3) begin
            chk(settle_err == 0, "R9 settle ticks", settle_err, 0);
            chk(scan_err == 0, "R9 scan order", scan_err, 0);
            chk(nscan == (er == 3 ? bad_idx + 1 : 16384), "R9 R10 scan length",
                nscan, er == 3 ? bad_idx + 1 : 16384);
        end else begin
            chk(nscan == 0, "R8 no scan", nscan, 0);
        end
        if (er == 3) chk(int'(fail_word) == bad_idx, "R10 fail word", int'(fail_word), bad_idx);
        if (mid_start) chk(cycles > 30 && wa[3] == tgt_addr, "R13 start ignored while busy",
                           int'(wa[3]), int'(tgt_addr));
        repeat (3) @(posedge clk);
        #2;
        chk(!done && result == res_seen, "R12 result held", int'(result), int'(res_seen));
    endtask

    initial begin
        #(CLK_PERIOD * 195000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #2;
        chk(!busy && !done && !wgate && !bus_rd && !bus_wr, "R1 reset idle", int'(busy), 0);
        @(posedge clk); #1 rst = 0;
        repeat (2) @(posedge clk);
        #2;
        chk(!busy && !bus_rd && !bus_wr, "R1 idle after reset", int'(bus_wr), 0);

        run_trial(6'd0, 1, 0, 0, 0, 1, 0);          // R11 plain success
        run_trial(6'd37, 1000, 0, 0, 0, 1, 0);      // R6 ready on the limit poll
        run_trial(6'd5, 0, 0, 0, 0, 1, 0);          // R6 timeout
        run_trial(6'd63, 3, 1, 0, 0, 2, 0);         // R8 erase error
        run_trial(6'd12, 2, 0, 1, 0, 1, 0);         // R10 first word bad
        run_trial(6'd20, 1, 0, 1, 16383, 1, 0);     // R10 last word bad
        run_trial(6'd9, 2, 0, 0, 0, 1, 1);          // R13 start while busy
        for (int t = 0; t < 4; t++) begin
            logic [5:0] b;
            int r, g, bi;
            bit e;
            b  = 6'($urandom_range(0, 63));
            r  = $urandom_range(1, 20);
            g  = $urandom_range(1, 3);
            e  = bit'($urandom_range(0, 1));
            bi = $urandom_range(0, 2000);
            run_trial(b, r, e, 1, bi, g, 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule